// File: doc/BRIEF.md
# Buffered Ten-Bit Pulse-Width Modulator

This block drives one pulse-width modulated output from an eight-bit period timer. A selectable input divider clocks the timer. Two sub-count bits taken from that divider are appended below the timer value, so the pulse width is set to ten bits of resolution. A duty tick is one clock at divide-by-1, four clocks at divide-by-4 and sixteen clocks at divide-by-16. Each timer step takes four duty ticks.

The ten-bit width comes in as an eight-bit upper part and a two-bit lower part. Either part may change at any moment. The value the comparator uses is a shadow copy, which is refreshed only when the timer wraps at its period limit, so a period never sees a half-updated width. Each wrap also feeds a programmable event divider, which raises a sticky interrupt flag once every N+1 wraps.

Top module: `pwm10_gen`

## Requirements
- R1: In reset and on the first cycle after it, `pwm_o` and `irq_o` read 0. The period register starts at 8'hFF and the timer at 0, so at divide-by-1 the boundaries come every 1024 clocks.
- R2: The timer counts from 0 up to the period value P and then returns to 0. One period lasts (P+1)*4 duty ticks, and `irq_o` (divider N=0) marks each boundary.
- R3: The active width D is {`duty_hi_i`,`duty_lo_i`}, with the two low bits compared against the sub-count. The output is high for exactly D duty ticks at the start of every period, and it rises one clock after the boundary clock.
- R4: A width of 0 keeps `pwm_o` low for the whole period.
- R5: A width at or above the period length keeps `pwm_o` high for the whole period.
- R6: A width written during a period has no effect on that period. It takes effect from the next boundary.
- R7: `presc_sel_i` selects the divider: 0 gives 1:1, 1 gives 1:4, and 2 or 3 give 1:16. Both the period and the high time scale by that ratio.
- R8: With `post_sel_i` = N, `irq_o` is set once every N+1 boundaries. N does not change the PWM period or the high time.
- R9: Once set, `irq_o` stays 1 until `irq_clr_i` is sampled high. A set on the same clock as a clear wins.
- R10: While `pwm_en_i` is low, `pwm_o` is 0 from the next clock on.
- R11: While `tmr_en_i` is low, the divider and the timer hold their values. No boundary occurs, and `pwm_o` keeps its level.
- R12: A pulse on `period_wr_i` loads `period_i` into the period register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_wr_i | input | 1 | Load strobe for the period register |
| period_i | input | 8 | New period value |
| duty_hi_i | input | 8 | Upper eight bits of the pending width |
| duty_lo_i | input | 2 | Lower two bits of the pending width |
| presc_sel_i | input | 2 | Timer input divider select |
| post_sel_i | input | 4 | Boundary event divider, N+1 |
| tmr_en_i | input | 1 | Timer run enable |
| pwm_en_i | input | 1 | Output enable; low forces the output to 0 |
| irq_clr_i | input | 1 | Clears the sticky interrupt flag |
| pwm_o | output | 1 | Registered PWM level |
| irq_o | output | 1 | Sticky boundary interrupt flag |

## Verification
A boundary clock sets `irq_o` on the same edge that returns the timer to zero. The shadow width is also loaded on that edge. `pwm_o` follows one clock later, because it is registered from the time base. The bench therefore uses the first falling edge where `irq_o` reads 1 as period sample zero, and it counts `pwm_o` high over exactly the next (P+1)*4*ratio falling edges. That count equals the width in clocks, and the following interval to the next flag equals the period length. Enable and clear responses are due one clock after the input changes and are sampled on the next falling edge.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  // each divider step multiplies the ratio by 2**PRE_LOG_STEP
  localparam int PRE_LOG_STEP = 2;

  typedef enum logic [1:0] {
    PRE_DIV1  = 2'd0,
    PRE_DIV4  = 2'd1,
    PRE_DIV16 = 2'd2
  } pre_div_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler import pwm10_pkg::*; #(
  parameter int SUB_W = 2,
  parameter int STEPS = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [$clog2(STEPS)-1:0]   sel,
  output logic [SUB_W-1:0]           sub,
  output logic                       step
);
  localparam int SEL_W = $clog2(STEPS);
  localparam int CNT_W = SUB_W + PRE_LOG_STEP * (STEPS - 1);

  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] sub_opt  [STEPS];
  logic             wrap_opt [STEPS];
  logic [SEL_W-1:0] idx;

  // one candidate sub-count and wrap test per divide ratio
  for (genvar g = 0; g < STEPS; g++) begin : g_ratio
    assign sub_opt[g]  = cnt[PRE_LOG_STEP*g +: SUB_W];
    assign wrap_opt[g] = &cnt[PRE_LOG_STEP*g+SUB_W-1:0];
  end

  assign idx  = (int'(sel) >= STEPS) ? SEL_W'(STEPS - 1) : sel;
  assign sub  = sub_opt[idx];
  assign step = en & wrap_opt[idx];

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (en)  cnt <= wrap_opt[idx] ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             period_wr,
  input  logic [TMR_W-1:0] period_in,
  output logic [TMR_W-1:0] tmr,
  output logic             roll
);
  logic [TMR_W-1:0] period_q;

  assign roll = step & (tmr == period_q);

  always_ff @(posedge clk) begin
    if (rst)            period_q <= '1;
    else if (period_wr) period_q <= period_in;
  end

  always_ff @(posedge clk) begin
    if (rst)       tmr <= '0;
    else if (roll) tmr <= '0;
    else if (step) tmr <= tmr + 1'b1;
  end

  // R2: a boundary happens only at the period limit, so the timer starts over from zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    roll |=> (tmr == '0));
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              roll,
  input  logic [POST_W-1:0] sel,
  input  logic              clr,
  output logic              irq
);
  logic [POST_W-1:0] cnt;
  logic              hit;

  assign hit = roll & (cnt >= sel);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (hit)  cnt <= '0;
    else if (roll) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (hit) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);

  p_set_src_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(roll));
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen import pwm10_pkg::*; #(
  parameter int TMR_W     = 8,
  parameter int SUB_W     = 2,
  parameter int POST_W    = 4,
  parameter int PRE_STEPS = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           period_wr_i,
  input  logic [TMR_W-1:0]               period_i,
  input  logic [TMR_W-1:0]               duty_hi_i,
  input  logic [SUB_W-1:0]               duty_lo_i,
  input  logic [$clog2(PRE_STEPS)-1:0]   presc_sel_i,
  input  logic [POST_W-1:0]              post_sel_i,
  input  logic                           tmr_en_i,
  input  logic                           pwm_en_i,
  input  logic                           irq_clr_i,
  output logic                           pwm_o,
  output logic                           irq_o
);
  localparam int DUTY_W = TMR_W + SUB_W;

  logic              step;
  logic [SUB_W-1:0]  sub;
  logic [TMR_W-1:0]  tmr;
  logic              roll;
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0] tbase;
  logic              pwm_q;

  pwm_prescaler #(.SUB_W(SUB_W), .STEPS(PRE_STEPS)) u_pre (
    .clk(clk), .rst(rst), .en(tmr_en_i), .sel(presc_sel_i),
    .sub(sub), .step(step)
  );

  pwm_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk(clk), .rst(rst), .step(step), .period_wr(period_wr_i),
    .period_in(period_i), .tmr(tmr), .roll(roll)
  );

  pwm_postscaler #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst(rst), .roll(roll), .sel(post_sel_i),
    .clr(irq_clr_i), .irq(irq_o)
  );

  assign tbase = {tmr, sub};

  // shadow width: loaded only at the period boundary
  always_ff @(posedge clk) begin
    if (rst)       duty_act <= '0;
    else if (roll) duty_act <= {duty_hi_i, duty_lo_i};
  end

  // high while the time base is below the width: set at the period start
  // unless the width is 0, cleared on equality, never cleared if past the period
  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_en_i & (tbase < duty_act);
  end

  assign pwm_o = pwm_q;

  p_off_r10: assert property (@(posedge clk) disable iff (rst)
    !pwm_en_i |=> !pwm_o);

  p_zero_low_r4: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |=> !pwm_o);

  p_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    !roll |=> $stable(duty_act));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !tmr_en_i |=> $stable(tmr));
endmodule

// File: tb/test_pwm10_gen.sv
module test_pwm10_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       period_wr;
  logic [7:0] period_in;
  logic [7:0] duty_hi;
  logic [1:0] duty_lo;
  logic [1:0] presc_sel;
  logic [3:0] post_sel;
  logic       tmr_en, pwm_en, irq_clr;
  logic       pwm_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pwm10_gen i_pwm10_gen (
    .clk(clk), .rst(rst), .period_wr_i(period_wr), .period_i(period_in),
    .duty_hi_i(duty_hi), .duty_lo_i(duty_lo), .presc_sel_i(presc_sel),
    .post_sel_i(post_sel), .tmr_en_i(tmr_en), .pwm_en_i(pwm_en),
    .irq_clr_i(irq_clr), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_duty(input int d);
    duty_hi = 8'(d >> 2);
    duty_lo = 2'(d);
  endtask

  task automatic set_period(input int p);
    period_in = 8'(p);
    period_wr = 1'b1;
    @(negedge clk);
    period_wr = 1'b0;
  endtask

  // clear the flag, then stop on the falling edge where it reads 1 (boundary edge just passed)
  task automatic sync();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    while (!irq_o) @(negedge clk);
  endtask

  // clocks from now to the next flag set
  task automatic count_to_irq(output int n);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    n = 1;
    while (!irq_o) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_high(input int len, output int highs);
    highs = 0;
    repeat (len) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
  endtask

  // one period at width d: high count and the following period length
  task automatic t_width(input string req, input int p, input int pre, input int d,
                         input int exp_high);
    int highs, len, ratio;
    ratio = (pre == 0) ? 1 : (pre == 1) ? 4 : 16;
    presc_sel = 2'(pre);
    set_duty(d);
    set_period(p);
    sync();
    count_high((p + 1) * 4 * ratio, highs);
    chk(req, highs, exp_high);
    count_to_irq(len);
    chk({req, " R2 period"}, len, (p + 1) * 4 * ratio);
  endtask

  task automatic t_reset();
    int len;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_o), 0);
    chk("R1 irq in reset", int'(irq_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pwm after reset", int'(pwm_o), 0);
    chk("R1 irq after reset", int'(irq_o), 0);
    sync();
    count_to_irq(len);
    chk("R1 default period FFh", len, 1024);
  endtask

  task automatic t_buffer();
    int h1, h2, h3;
    presc_sel = 2'd0;
    set_duty(10);
    set_period(9);
    sync();
    sync();
    count_high(20, h1);
    set_duty(30);           // written mid-period
    count_high(20, h2);
    chk("R6 old width kept this period", h1 + h2, 10);
    count_high(40, h3);
    chk("R6 new width from next period", h3, 30);
  endtask

  task automatic t_post();
    int len, highs;
    presc_sel = 2'd0;
    post_sel  = 4'd2;
    set_duty(10);
    set_period(9);
    sync();
    count_high(40, highs);
    chk("R8 width unchanged by event divider", highs, 10);
    sync();
    count_to_irq(len);
    chk("R8 flag every 3 boundaries", len, 120);
    post_sel = 4'd0;
  endtask

  task automatic t_sticky();
    int ones;
    sync();
    ones = 0;
    repeat (200) begin
      @(negedge clk);
      if (irq_o) ones++;
    end
    chk("R9 flag stays set", ones, 200);
    tmr_en  = 1'b0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 clear drops flag", int'(irq_o), 0);
    tmr_en = 1'b1;
  endtask

  task automatic t_pwm_off();
    int highs;
    set_duty(30);
    set_period(9);
    sync();
    pwm_en = 1'b0;
    count_high(40, highs);
    chk("R10 disabled output low", highs, 0);
    pwm_en = 1'b1;
    sync();
    count_high(40, highs);
    chk("R10 re-enabled output resumes", highs, 30);
  endtask

  task automatic t_hold();
    int highs, ones;
    set_duty(20);
    set_period(9);
    sync();
    repeat (10) @(negedge clk);
    tmr_en  = 1'b0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    ones = 0;
    highs = 0;
    repeat (300) begin
      @(negedge clk);
      if (pwm_o) highs++;
      if (irq_o) ones++;
    end
    chk("R11 level held while stopped", highs, 300);
    chk("R11 no boundary while stopped", ones, 0);
    tmr_en = 1'b1;
    sync();
    chk("R11 boundary after restart", int'(irq_o), 1);
  endtask

  initial begin
    rst = 1'b1; period_wr = 1'b0; period_in = 8'd0;
    duty_hi = 8'd0; duty_lo = 2'd0; presc_sel = 2'd0; post_sel = 4'd0;
    tmr_en = 1'b1; pwm_en = 1'b1; irq_clr = 1'b0;
    t_reset();
    t_width("R3 R12 half width", 199, 0, 400, 400);
    t_width("R3 width 768", 199, 0, 768, 768);
    t_width("R3 low bits resolve one tick", 9, 0, 13, 13);
    t_width("R4 zero width", 9, 0, 0, 0);
    t_width("R5 width above period", 9, 0, 100, 40);
    t_width("R5 width equal to period", 9, 0, 40, 40);
    t_width("R5 width one below period", 9, 0, 39, 39);
    t_width("R7 divide by 4", 9, 1, 21, 84);
    t_width("R7 divide by 16", 3, 2, 6, 96);
    t_width("R7 code 3 is divide by 16", 3, 3, 5, 80);
    t_buffer();
    t_post();
    t_sticky();
    t_pwm_off();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule